// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block produces pseudo-random test patterns for built-in self-test from a one-dimensional row of cells. On every enabled clock each cell takes a new value from itself and its two adjacent cells only. Each cell follows one of two linear rules. A rule-90 cell takes the XOR of its two neighbours. A rule-150 cell takes the XOR of both neighbours and its own value. Because every connection is local, the block has no long feedback wire, and adjacent bits are less correlated than in a shift-register source.

The rule for each cell comes from a parameter mask. By default the rules alternate, with cell 0 on rule 90. The cells beyond each end of the row read as constant zero. Software or a test controller can load a seed at any time, and a seed load takes priority over stepping. The all-zero state is a lock-up state, so an all-zero seed is replaced by a single one in cell 0.

Top module: `hybrid_ca_gen`

## Requirements
- R1: While reset is low at a clock edge, the pattern becomes the value 1 after that edge, which means only cell 0 is set.
- R2: A cell whose mask bit is 0 (rule 90) takes the XOR of cell i-1 and cell i+1 on an enabled step. Over the neighbourhood (i-1, i, i+1) read from 111 down to 000, this rule gives the outputs 0,1,0,1,1,0,1,0.
- R3: A cell whose mask bit is 1 (rule 150) takes the XOR of cell i-1, cell i and cell i+1 on an enabled step.
- R4: The missing neighbour of cell 0 and the missing neighbour of cell N-1 are read as 0.
- R5: By default the mask alternates along the row, with bit i equal to i mod 2, so cell 0 uses rule 90.
- R6: When `seed_load` is high at a clock edge, the pattern takes the value of `seed_val` after that edge.
- R7: A seed load takes priority over `step_en` when both are high in the same cycle.
- R8: An all-zero seed loads the value 1.
- R9: When neither `seed_load` nor `step_en` is high, the pattern holds its value.
- R10: With 5 cells and mask 5'b00011, the generator starts from any nonzero state and passes through all 31 nonzero states before it returns to that state. It never reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load `seed_val` into the cells |
| seed_val | input | N_CELLS | Seed value, with bit i going to cell i |
| step_en | input | 1 | Advance the automaton by one step |
| pattern | output | N_CELLS | Current cell states, with bit i from cell i |

## Verification
The bench builds two instances with N_CELLS = 5. The first uses the default alternating mask. The second uses mask 5'b00011, whose characteristic polynomial x^5+x^3+x^2+x+1 is primitive. The width is kept at 5 so that the whole state space of 32 values fits within one walk. This lets the bench confirm the full 31-state cycle of the second instance. For the default instance, the bench measures the period it reaches and reports that value. Single-bit seeds at each end of the row show that the boundary cells read zero outside the row.

// File: rtl/ca_pkg.sv
// Shared types for the hybrid cellular automaton pattern generator.
// Assumes a row of at most MAX_CELLS cells.
package ca_pkg;
    localparam int MAX_CELLS = 64;

    // Update rule of one cell.
    typedef enum logic {
        RULE_90  = 1'b0,
        RULE_150 = 1'b1
    } ca_rule_e;

    // Alternating rule mask with cell 0 on rule 90; truncated to the row width.
    localparam logic [MAX_CELLS-1:0] ALT_RULES = {(MAX_CELLS/2){2'b10}};
endpackage

// File: rtl/ca_cell.sv
// One automaton cell: a flop that loads a seed bit, steps by its rule, or holds.
// Assumes left_in/right_in are already zero at the row boundary.
module ca_cell #(
    parameter ca_pkg::ca_rule_e RULE    = ca_pkg::RULE_90,
    parameter logic             RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    input  logic adv,
    input  logic left_in,
    input  logic right_in,
    output logic q
);
    logic nxt;

    // Rule variant chosen at elaboration.
    generate
        if (RULE == ca_pkg::RULE_150) begin : g_r150
            always_comb nxt = left_in ^ q ^ right_in;
        end else begin : g_r90
            always_comb nxt = left_in ^ right_in;
        end
    endgenerate

    // State flop: reset, then seed load over step over hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_VAL;
        else if (load)  q <= load_bit;
        else if (adv)   q <= nxt;
    end
endmodule

// File: rtl/ca_seed_guard.sv
// Replaces an all-zero seed with a single one in cell 0 so the row cannot lock up.
// Purely combinational.
module ca_seed_guard #(
    parameter int N_CELLS = 5
) (
    input  logic [N_CELLS-1:0] seed_in,
    output logic [N_CELLS-1:0] seed_out
);
    localparam logic [N_CELLS-1:0] ONE_HOT0 = N_CELLS'(1);

    // Substitute the lock-up state.
    always_comb seed_out = (seed_in == '0) ? ONE_HOT0 : seed_in;
endmodule

// File: rtl/hybrid_ca_gen.sv
// Hybrid rule-90/150 cellular automaton pattern generator with null boundaries.
// RULE_SEL bit i = 1 puts cell i on rule 150. Assumes 2 <= N_CELLS <= 64.
module hybrid_ca_gen #(
    parameter int                 N_CELLS  = 5,
    parameter logic [N_CELLS-1:0] RULE_SEL = N_CELLS'(ca_pkg::ALT_RULES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [N_CELLS-1:0] seed_val,
    input  logic               step_en,
    output logic [N_CELLS-1:0] pattern
);
    localparam logic [N_CELLS-1:0] RESET_PAT = N_CELLS'(1);
    localparam int                 LAST      = N_CELLS - 1;

    logic [N_CELLS-1:0] seed_safe;
    logic [N_CELLS-1:0] state;
    logic [N_CELLS-1:0] left_nb;
    logic [N_CELLS-1:0] right_nb;

    ca_seed_guard #(.N_CELLS(N_CELLS)) u_guard (
        .seed_in  (seed_val),
        .seed_out (seed_safe)
    );

    // One cell per position; neighbours tied to zero past either end.
    generate
        for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
            if (i == 0) begin : g_lo
                assign left_nb[i] = 1'b0;
            end else begin : g_lm
                assign left_nb[i] = state[i-1];
            end
            if (i == LAST) begin : g_hi
                assign right_nb[i] = 1'b0;
            end else begin : g_rm
                assign right_nb[i] = state[i+1];
            end
            ca_cell #(
                .RULE    (RULE_SEL[i] ? ca_pkg::RULE_150 : ca_pkg::RULE_90),
                .RST_VAL (RESET_PAT[i])
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (seed_load),
                .load_bit (seed_safe[i]),
                .adv      (step_en),
                .left_in  (left_nb[i]),
                .right_in (right_nb[i]),
                .q        (state[i])
            );
        end
    endgenerate

    assign pattern = state;

    // R1: reset leaves only cell 0 set.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> pattern == RESET_PAT);

    // R6: a nonzero seed appears on the next cycle.
    a_r6_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_val != '0) |=> pattern == $past(seed_val));

    // R7: a load wins over a step in the same cycle.
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && step_en && seed_val != '0) |=> pattern == $past(seed_val));

    // R8: an all-zero seed becomes the value 1.
    a_r8_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_val == '0) |=> pattern == RESET_PAT);

    // R9: idle cycles hold the pattern.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !step_en) |=> $stable(pattern));
endmodule

// File: tb/sim_hybrid_ca_gen.sv
`timescale 1ns/1ps
module sim_hybrid_ca_gen;
    localparam int N = 5;
    localparam logic [N-1:0] MASK_ALT = 5'b01010;
    localparam logic [N-1:0] MASK_MAX = 5'b00011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seed_load = 1'b0;
    logic [N-1:0] seed_val = '0;
    logic step_en = 1'b0;
    logic [N-1:0] pat0, pat1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [N-1:0] e0;
        logic [N-1:0] e1;
        string        tag;
    } exp_t;
    exp_t sb[$];

    logic [N-1:0] m0, m1;

    always #2.5 clk = ~clk;

    hybrid_ca_gen #(.N_CELLS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .step_en(step_en), .pattern(pat0));

    hybrid_ca_gen #(.N_CELLS(N), .RULE_SEL(MASK_MAX)) u1 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .step_en(step_en), .pattern(pat1));

    // Reference step from the rule truth tables (90 and 150), zero outside the row.
    function automatic logic [N-1:0] ref_step(logic [N-1:0] s, logic [N-1:0] mask);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic l, c, rt;
            logic [7:0] tbl;
            l   = (i > 0)     ? s[i-1] : 1'b0;
            rt  = (i < N - 1) ? s[i+1] : 1'b0;
            c   = s[i];
            tbl = mask[i] ? 8'd150 : 8'd90;
            r[i] = tbl[{l, c, rt}];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic drive(bit ld, logic [N-1:0] sd, bit en, string tag);
        exp_t it;
        @(negedge clk);
        seed_load = ld; seed_val = sd; step_en = en;
        if (ld) begin
            m0 = (sd == '0) ? N'(1) : sd;
            m1 = m0;
        end else if (en) begin
            m0 = ref_step(m0, MASK_ALT);
            m1 = ref_step(m1, MASK_MAX);
        end
        @(posedge clk);
        #1;
        it.e0 = m0; it.e1 = m1; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare both instances against the queued items.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(pat0 === it.e0, {it.tag, " u0"}, pat0, it.e0);
            check(pat1 === it.e1, {it.tag, " u1"}, pat1, it.e1);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int period;
        int visited;
        bit seen [32];
        logic [N-1:0] hist [0:64];
        int rep_at;
        int rep_from;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset value
        check(pat0 === N'(1), "R1 reset u0", pat0, N'(1));
        check(pat1 === N'(1), "R1 reset u1", pat1, N'(1));
        rst_n = 1'b1;
        m0 = N'(1); m1 = N'(1);

        // R2 R3 R5: stepping from the reset state
        for (int k = 0; k < 6; k++) drive(1'b0, '0, 1'b1, "R2 R3 R5 step");
        // R9: hold
        drive(1'b0, 5'b10101, 1'b0, "R9 hold");
        drive(1'b0, '0, 1'b0, "R9 hold");
        // R6: load nonzero seeds
        drive(1'b1, 5'b10110, 1'b0, "R6 load");
        for (int k = 0; k < 3; k++) drive(1'b0, '0, 1'b1, "R2 R3 step after load");
        // R7: load with enable
        drive(1'b1, 5'b01101, 1'b1, "R7 load wins");
        // R8: zero seed
        drive(1'b1, 5'b00000, 1'b1, "R8 zero seed");
        // R4: single bits at both ends
        drive(1'b1, 5'b10000, 1'b0, "R6 load high end");
        drive(1'b0, '0, 1'b1, "R4 high boundary");
        drive(1'b0, '0, 1'b1, "R4 high boundary");
        drive(1'b1, 5'b00001, 1'b0, "R6 load low end");
        drive(1'b0, '0, 1'b1, "R4 low boundary");
        drive(1'b1, 5'b11111, 1'b0, "R6 load all ones");
        drive(1'b0, '0, 1'b1, "R4 R2 R3 full row");
        for (int k = 0; k < 4; k++) drive(1'b0, '0, 1'b1, "R2 R3 walk");
        @(negedge clk);
        @(negedge clk);

        // R10: period walk from seed 1
        seed_load = 1'b1; seed_val = N'(1); step_en = 1'b0;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b1;
        for (int k = 0; k < 32; k++) seen[k] = 1'b0;
        hist[0] = pat0;
        period = 0;
        visited = 0;
        rep_at = -1;
        rep_from = -1;
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk);
            hist[k] = pat0;
            if (rep_at < 0) begin
                for (int j = 0; j < k; j++)
                    if (rep_at < 0 && hist[j] == pat0) begin
                        rep_at = k; rep_from = j;
                    end
            end
            if (period == 0) begin
                if (!seen[pat1]) visited++;
                seen[pat1] = 1'b1;
                if (pat1 == N'(1)) period = k;
                check(pat1 != '0, "R10 nonzero state", pat1, N'(1));
            end
        end
        step_en = 1'b0;
        check(period == 31, "R10 period", N'(period), N'(31));
        check(visited == 31, "R10 distinct states", N'(visited), N'(31));
        if (rep_at > 0)
            $display("INFO default mask: state repeats after %0d steps (cycle length %0d)",
                     rep_at, rep_at - rep_from);
        else
            $display("INFO default mask: no repeat within 64 steps");

        finish_run();
    end
endmodule